// File: doc/BRIEF.md
# Interleaved Scratch Address Generator

This block maps the private (scratch) byte address of one lane of a 64-lane wavefront to a physical byte address, so that every lane owns its own interleaved slots in a shared scratch area. Memory is laid out element by element: for a given element index, the 64 lanes hold 64 neighbouring elements. The element size is programmable at 2, 4, 8 or 16 bytes. The physical address is the dispatch scratch base plus the per-wave byte offset plus the interleaved position of the lane's element plus the byte offset inside that element.

A request carries a lane number, a private address and an access width. An access that fits in one element leaves as one beat. An access wider than the element is cut into element-sized beats. Each beat lands inside one of the requesting lane's own elements. The beats leave in ascending private-address order on a valid/ready output stream. A request that is not aligned to its own width, or that has an illegal width code, is dropped and raises a one-cycle error pulse.

The configuration inputs (base, wave offset, element-size code) are sampled when a request is accepted. They may change while that request's beats are still being issued.

Top module: `scratch_swizzle_agu`

## Requirements
- R1: The element-size code `cfg_elem_code` selects the element size: 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes, 3 = 16 bytes.
- R2: For element size E, a beat at private address A from lane L has physical address base + wave_offset + ((A / E) * 64 + L) * E + (A mod E).
- R3: The access-size code `req_size` gives 2^code bytes for codes 0 to 4 (1, 2, 4, 8, 16 bytes). An aligned access no wider than E leaves as exactly one beat. That beat has `beat_bytes` equal to the access width and `beat_last` = 1.
- R4: An aligned access of width W > E leaves as W/E beats of E bytes each, at private addresses A, A+E, A+2E, and so on in ascending order. Each beat's physical address is 64*E above the previous one. With `beat_ready` held high, one beat leaves per cycle.
- R5: `beat_last` is 1 on the final beat of a request and 0 on every earlier beat.
- R6: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, byte count and last flag hold steady and `beat_valid` stays 1.
- R7: A request is dropped if its address is not a multiple of its width, or if its size code is 5, 6 or 7. A dropped request produces no beat, and `err_misalign` is 1 for exactly the cycle after it is accepted.
- R8: `req_ready` is 1 only when no beat is pending. A request is accepted on a cycle with `req_valid` and `req_ready` both 1, and its first beat is valid in the next cycle. Configuration changes after acceptance do not affect that request's beats.
- R9: After reset, `req_ready` = 1, `beat_valid` = 0 and `err_misalign` = 0.
- R10: The lane number always enters the interleave: two lanes with the same private address and element size E get physical addresses that differ by (lane difference) * E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_scratch_base | input | ADDR_W | Dispatch scratch base byte address |
| cfg_wave_offset | input | OFF_W | Per-wave byte offset added to the base |
| cfg_elem_code | input | 2 | Element-size code (R1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_lane | input | LANE_W | Requesting lane number |
| req_addr | input | PRIV_W | Private byte address |
| req_size | input | 3 | Access-size code, width = 2^code bytes |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Physical byte address of the beat |
| beat_bytes | output | 5 | Byte count of the beat |
| beat_last | output | 1 | Final beat of the request |
| err_misalign | output | 1 | One-cycle pulse for a dropped request |

## Verification
The assertions check these properties on every cycle:
- the output stream holds steady under backpressure;
- `req_ready` is never high while a beat is pending;
- each split beat lands exactly 64 elements above the one before it;
- beat byte counts are legal powers of two;
- an error pulse never coincides with a beat and always follows an acceptance.

Only the bench's scenarios can show the rest. That covers the absolute address value against the interleave formula for every element size, the per-lane offset at lanes 0 and 63, and the exact beat count and last flag of a split. It also covers that a misaligned or illegally sized request produces no beat at all, and that a configuration change after acceptance leaves the issued addresses untouched.

// File: rtl/scratch_swz_pkg.sv
package scratch_swz_pkg;

  // Element-size selection, value = log2(bytes) - 1
  typedef enum logic [1:0] {
    ELEM_2B  = 2'd0,
    ELEM_4B  = 2'd1,
    ELEM_8B  = 2'd2,
    ELEM_16B = 2'd3
  } elem_code_e;

  // Access widths, value = log2(bytes); codes above ACC_16B are illegal
  typedef enum logic [2:0] {
    ACC_1B  = 3'd0,
    ACC_2B  = 3'd1,
    ACC_4B  = 3'd2,
    ACC_8B  = 3'd3,
    ACC_16B = 3'd4
  } acc_code_e;

  localparam int unsigned MAX_ACC_LOG = 4;
  localparam int unsigned CNT_W       = 3;  // beats - 1, at most 7

  // log2 of element bytes
  function automatic logic [2:0] elem_log2(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

endpackage

// File: rtl/swz_rst_sync.sv
module swz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/swz_req_decode.sv
module swz_req_decode
  import scratch_swz_pkg::*;
#(
  parameter int unsigned PRIV_W = 24
) (
  input  logic [PRIV_W-1:0] addr,
  input  logic [2:0]        size_code,
  input  logic [1:0]        elem_code,
  output logic              bad,
  output logic [2:0]        beat_log,
  output logic [CNT_W-1:0]  cnt_m1
);
  logic [2:0] acc_log;
  logic [2:0] es_log;
  logic [3:0] low_mask;
  logic       illegal;
  logic       misal;
  logic [2:0] ratio_log;

  always_comb begin
    acc_log   = size_code;
    es_log    = elem_log2(elem_code);
    illegal   = (size_code > 3'(MAX_ACC_LOG));
    low_mask  = 4'((5'd1 << acc_log) - 5'd1);
    misal     = |(addr[3:0] & low_mask);
    bad       = illegal | misal;
    ratio_log = 3'd0;
    if (acc_log > es_log) begin
      beat_log  = es_log;
      ratio_log = acc_log - es_log;
    end else begin
      beat_log  = acc_log;
    end
    cnt_m1 = CNT_W'((4'd1 << ratio_log) - 4'd1);
  end
endmodule

// File: rtl/swz_addr_map.sv
module swz_addr_map #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PRIV_W = 24,
  parameter int unsigned LANE_W = 6
) (
  input  logic [ADDR_W-1:0] base_sum,
  input  logic [PRIV_W-1:0] priv_addr,
  input  logic [LANE_W-1:0] lane,
  input  logic [2:0]        es_log,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int unsigned SLOT_W = PRIV_W + LANE_W;

  logic [PRIV_W-1:0] elem_idx;
  logic [PRIV_W-1:0] in_elem;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] slot_bytes;

  always_comb begin
    elem_idx   = priv_addr >> es_log;
    in_elem    = priv_addr & ((PRIV_W'(1) << es_log) - PRIV_W'(1));
    slot       = {elem_idx, lane};  // element index * lanes + lane
    slot_bytes = ADDR_W'(slot) << es_log;
    phys_addr  = base_sum + slot_bytes + ADDR_W'(in_elem);
  end
endmodule

// File: rtl/swz_beat_seq.sv
module swz_beat_seq
  import scratch_swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PRIV_W = 24,
  parameter int unsigned LANE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bad,
  input  logic [ADDR_W-1:0] new_base_sum,
  input  logic [PRIV_W-1:0] new_addr,
  input  logic [LANE_W-1:0] new_lane,
  input  logic [2:0]        new_es_log,
  input  logic [2:0]        new_beat_log,
  input  logic [CNT_W-1:0]  new_cnt_m1,
  input  logic              out_ready,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] cur_base_sum,
  output logic [PRIV_W-1:0] cur_addr,
  output logic [LANE_W-1:0] cur_lane,
  output logic [2:0]        cur_es_log,
  output logic [2:0]        cur_beat_log,
  output logic              cur_last
);
  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [PRIV_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_q;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        es_q, bl_q;
  logic              load_en;
  logic              step_en;

  assign load_en = accept;
  assign step_en = busy_q & out_ready;

  // next state
  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    err_d  = 1'b0;
    if (load_en) begin
      err_d  = bad;
      busy_d = ~bad;
      rem_d  = new_cnt_m1;
      addr_d = new_addr;
    end else if (step_en) begin
      if (rem_q == '0) begin
        busy_d = 1'b0;
      end else begin
        rem_d  = rem_q - CNT_W'(1);
        addr_d = addr_q + (PRIV_W'(1) << bl_q);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  // datapath registers, clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (load_en | step_en) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
    if (load_en) begin
      base_q <= new_base_sum;
      lane_q <= new_lane;
      es_q   <= new_es_log;
      bl_q   <= new_beat_log;
    end
  end

  assign busy         = busy_q;
  assign err          = err_q;
  assign cur_base_sum = base_q;
  assign cur_addr     = addr_q;
  assign cur_lane     = lane_q;
  assign cur_es_log   = es_q;
  assign cur_beat_log = bl_q;
  assign cur_last     = (rem_q == '0);
endmodule

// File: rtl/scratch_swizzle_agu.sv
module scratch_swizzle_agu
  import scratch_swz_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned PRIV_W = 24,
  parameter int unsigned LANES  = 64,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_scratch_base,
  input  logic [OFF_W-1:0]  cfg_wave_offset,
  input  logic [1:0]        cfg_elem_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [PRIV_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [4:0]        beat_bytes,
  output logic              beat_last,
  output logic              err_misalign
);
  logic              rst_sync_n;
  logic              accept;
  logic              bad;
  logic [2:0]        dec_beat_log;
  logic [CNT_W-1:0]  dec_cnt_m1;
  logic [ADDR_W-1:0] new_base_sum;
  logic              busy;
  logic [ADDR_W-1:0] cur_base_sum;
  logic [PRIV_W-1:0] cur_addr;
  logic [LANE_W-1:0] cur_lane;
  logic [2:0]        cur_es_log;
  logic [2:0]        cur_beat_log;
  logic              cur_last;

  swz_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign req_ready    = ~busy;
  assign accept       = req_valid & req_ready;
  assign new_base_sum = cfg_scratch_base + ADDR_W'(cfg_wave_offset);

  swz_req_decode #(.PRIV_W(PRIV_W)) u_dec (
    .addr      (req_addr),
    .size_code (req_size),
    .elem_code (cfg_elem_code),
    .bad       (bad),
    .beat_log  (dec_beat_log),
    .cnt_m1    (dec_cnt_m1)
  );

  swz_beat_seq #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .LANE_W(LANE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .accept       (accept),
    .bad          (bad),
    .new_base_sum (new_base_sum),
    .new_addr     (req_addr),
    .new_lane     (req_lane),
    .new_es_log   (elem_log2(cfg_elem_code)),
    .new_beat_log (dec_beat_log),
    .new_cnt_m1   (dec_cnt_m1),
    .out_ready    (beat_ready),
    .busy         (busy),
    .err          (err_misalign),
    .cur_base_sum (cur_base_sum),
    .cur_addr     (cur_addr),
    .cur_lane     (cur_lane),
    .cur_es_log   (cur_es_log),
    .cur_beat_log (cur_beat_log),
    .cur_last     (cur_last)
  );

  swz_addr_map #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .LANE_W(LANE_W)) u_map (
    .base_sum  (cur_base_sum),
    .priv_addr (cur_addr),
    .lane      (cur_lane),
    .es_log    (cur_es_log),
    .phys_addr (beat_addr)
  );

  assign beat_valid = busy;
  assign beat_bytes = 5'(5'd1 << cur_beat_log);
  assign beat_last  = cur_last;
endmodule

// File: rtl/scratch_swizzle_agu_chk.sv
module scratch_swizzle_agu_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LANES  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [4:0]        beat_bytes,
  input logic              beat_last,
  input logic              err_misalign
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_bytes) && $stable(beat_last)); // R6

  AST_NO_READY_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R8

  AST_FIRST_BEAT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> $past(req_valid && req_ready)); // R8

  AST_SPLIT_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=>
      beat_valid && (beat_addr == $past(beat_addr) + ADDR_W'(LANES) * ADDR_W'($past(beat_bytes)))); // R4

  AST_BEAT_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> $onehot(beat_bytes)); // R3

  AST_ERR_DROPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |-> !beat_valid); // R7

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |-> $past(req_valid && req_ready)); // R7
endmodule

bind scratch_swizzle_agu scratch_swizzle_agu_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .beat_valid   (beat_valid),
  .beat_ready   (beat_ready),
  .beat_addr    (beat_addr),
  .beat_bytes   (beat_bytes),
  .beat_last    (beat_last),
  .err_misalign (err_misalign)
);

// File: tb/scratch_swizzle_agu_bench.sv
module scratch_swizzle_agu_bench;
  localparam int ADDR_W = 48;
  localparam int OFF_W  = 32;
  localparam int PRIV_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] cfg_scratch_base;
  logic [OFF_W-1:0]  cfg_wave_offset;
  logic [1:0]        cfg_elem_code;
  logic              req_valid;
  logic              req_ready;
  logic [5:0]        req_lane;
  logic [PRIV_W-1:0] req_addr;
  logic [2:0]        req_size;
  logic              beat_valid;
  logic              beat_ready;
  logic [ADDR_W-1:0] beat_addr;
  logic [4:0]        beat_bytes;
  logic              beat_last;
  logic              err_misalign;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  scratch_swizzle_agu u_scratch_swizzle_agu (
    .clk(clk), .rst_n(rst_n),
    .cfg_scratch_base(cfg_scratch_base), .cfg_wave_offset(cfg_wave_offset),
    .cfg_elem_code(cfg_elem_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_lane(req_lane),
    .req_addr(req_addr), .req_size(req_size),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_bytes(beat_bytes), .beat_last(beat_last), .err_misalign(err_misalign)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference interleave: base + off + ((a/E)*64 + lane)*E + a%E
  function automatic logic [ADDR_W-1:0] ref_phys(input int lane, input longint a, input int es,
                                                 input longint base, input longint off);
    longint e;
    e = 2 << es;
    return ADDR_W'(base + off + ((a / e) * 64 + lane) * e + (a % e));
  endfunction

  task automatic send(input int lane, input int addr, input int size, input string req);
    @(negedge clk);
    chk(req_ready == 1'b1, req, "req_ready before send", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_lane  = 6'(lane);
    req_addr  = PRIV_W'(addr);
    req_size  = 3'(size);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // called at the negedge right after acceptance
  task automatic expect_beats(input int lane, input int addr, input int size, input int es,
                              input longint base, input longint off, input int stall,
                              input string req);
    int acc, e, bw, n;
    acc = 1 << size;
    e   = 2 << es;
    bw  = (acc < e) ? acc : e;
    n   = acc / bw;
    for (int k = 0; k < n; k++) begin
      logic [ADDR_W-1:0] exp_a;
      exp_a = ref_phys(lane, longint'(addr + k * bw), es, base, off);
      if (stall > 0) begin
        beat_ready = 1'b0;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(beat_valid && beat_addr == exp_a, "R6", "stalled beat held",
              64'(beat_addr), 64'(exp_a));
        end
        beat_ready = 1'b1;
      end
      chk(beat_valid == 1'b1, req, "beat_valid", 64'(beat_valid), 64'd1);
      chk(beat_addr == exp_a, req, "beat_addr", 64'(beat_addr), 64'(exp_a));
      chk(beat_bytes == 5'(bw), req, "beat_bytes", 64'(beat_bytes), 64'(bw));
      chk(beat_last == (k == n - 1), "R5", "beat_last", 64'(beat_last), 64'(k == n - 1));
      if (k < n - 1)
        chk(req_ready == 1'b0, "R8", "req_ready low while pending", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    chk(beat_valid == 1'b0, req, "no extra beat", 64'(beat_valid), 64'd0);
    chk(req_ready == 1'b1, "R8", "ready after drain", 64'(req_ready), 64'd1);
  endtask

  task automatic set_cfg(input longint base, input longint off, input int es);
    cfg_scratch_base = ADDR_W'(base);
    cfg_wave_offset  = OFF_W'(off);
    cfg_elem_code    = 2'(es);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
    chk(beat_valid == 1'b0, "R9", "reset beat_valid", 64'(beat_valid), 64'd0);
    chk(err_misalign == 1'b0, "R9", "reset err", 64'(err_misalign), 64'd0);
  endtask

  // R1 R2: one element-sized access for each element size
  task automatic t_each_esize;
    for (int es = 0; es < 4; es++) begin
      int a;
      a = 'h130 + (2 << es) * 3;
      set_cfg(64'h10_0000, 64'h400, es);
      send(5, a, es + 1, "R1");
      expect_beats(5, a, es + 1, es, 64'h10_0000, 64'h400, 0, "R2");
    end
  endtask

  // R3: narrow access inside a large element
  task automatic t_narrow;
    set_cfg(64'h2000, 64'h80, 2);
    send(9, 'h13, 0, "R3");
    expect_beats(9, 'h13, 0, 2, 64'h2000, 64'h80, 0, "R3");
    send(9, 'h16, 1, "R3");
    expect_beats(9, 'h16, 1, 2, 64'h2000, 64'h80, 0, "R3");
  endtask

  // R10: lane enters the interleave
  task automatic t_lanes;
    set_cfg(64'h0, 64'h0, 1);
    send(0, 'h40, 2, "R10");
    expect_beats(0, 'h40, 2, 1, 0, 0, 0, "R10");
    send(63, 'h40, 2, "R10");
    expect_beats(63, 'h40, 2, 1, 0, 0, 0, "R10");
  endtask

  // R4: split accesses
  task automatic t_split;
    set_cfg(64'h8000, 64'h100, 1);
    send(3, 'h108, 3, "R4");
    expect_beats(3, 'h108, 3, 1, 64'h8000, 64'h100, 0, "R4");
    set_cfg(64'h8000, 64'h100, 0);
    send(17, 'h40, 4, "R4");
    expect_beats(17, 'h40, 4, 0, 64'h8000, 64'h100, 0, "R4");
  endtask

  // R6: backpressure on a split
  task automatic t_stall;
    set_cfg(64'h4000, 64'h20, 2);
    send(7, 'h30, 4, "R6");
    expect_beats(7, 'h30, 4, 2, 64'h4000, 64'h20, 2, "R6");
  endtask

  // R7: misaligned and illegal size dropped
  task automatic t_errors;
    set_cfg(64'h0, 64'h0, 1);
    send(1, 'h102, 2, "R7");
    chk(err_misalign == 1'b1, "R7", "err on misaligned", 64'(err_misalign), 64'd1);
    chk(beat_valid == 1'b0, "R7", "no beat on misaligned", 64'(beat_valid), 64'd0);
    @(negedge clk);
    chk(err_misalign == 1'b0, "R7", "err one cycle", 64'(err_misalign), 64'd0);
    chk(beat_valid == 1'b0, "R7", "still no beat", 64'(beat_valid), 64'd0);
    send(1, 'h100, 5, "R7");
    chk(err_misalign == 1'b1, "R7", "err on size 5", 64'(err_misalign), 64'd1);
    chk(beat_valid == 1'b0, "R7", "no beat on size 5", 64'(beat_valid), 64'd0);
    @(negedge clk);
    chk(err_misalign == 1'b0, "R7", "err cleared", 64'(err_misalign), 64'd0);
  endtask

  // R8: config change after acceptance has no effect
  task automatic t_snapshot;
    set_cfg(64'h9000, 64'h44, 0);
    send(12, 'h20, 3, "R8");
    set_cfg(64'h7777_0000, 64'h999, 3);
    expect_beats(12, 'h20, 3, 0, 64'h9000, 64'h44, 0, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_lane = '0; req_addr = '0; req_size = '0;
    beat_ready = 1'b1;
    set_cfg(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_each_esize();
    t_narrow();
    t_lanes();
    t_split();
    t_stall();
    t_errors();
    t_snapshot();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule